// File: doc/BRIEF.md
# Timestamp Pulse Width Filter

This block sits in the timestamp readout path of a multi-channel time-to-digital converter. Each incoming record names a channel, says whether the edge was rising or falling, and carries the time of the edge as a seconds count plus a coarse count of 8 ns ticks. The coarse count runs from 0 to 124,999,999 within each second. In filtering mode the block parks each rising edge in a per-channel slot and waits for the falling edge on the same channel. It then measures the pulse width and forwards the parked rising record only when the width is inside the allowed window. Falling records are consumed and never leave the block.

The width window runs from a parameterised minimum (default 12 ticks, 96 ns) up to one full second (125,000,000 ticks). A second parameter bypasses the filter, so that every record flows through untouched. Both ports use valid/ready handshakes. A single output register gives back-pressure to the input, so no accepted pulse is lost while the consumer is stalled.

Top module: `timestamp_pw_filter`

## Requirements
- R1: With filtering enabled, no record with the slope flag at 0 (falling edge) ever appears on the output.
- R2: With filtering enabled, a rising record is not emitted when it is accepted. It becomes valid on the output in the cycle after the matching falling record of its channel is accepted, with channel, seconds and ticks unchanged and the slope flag at 1.
- R3: A pulse of exactly 125,000,000 ticks is forwarded. Any longer pulse, including one spanning two or more second boundaries, is dropped.
- R4: A pulse shorter than MIN_TICKS (default 12) is dropped, and a pulse of exactly MIN_TICKS ticks is forwarded.
- R5: Width is (falling seconds − rising seconds) × 125,000,000 + (falling ticks − rising ticks). A pulse that crosses one second boundary is therefore measured correctly even though the tick count wrapped.
- R6: A second rising record on a channel whose slot is already occupied overwrites the slot. Only the newer rising record can be forwarded.
- R7: A falling record on a channel with an empty slot is dropped and produces no output. A forwarded or rejected pulse empties its slot.
- R8: The NUM_CH (default 5) channels keep independent slots. Interleaved pulses on different channels are each judged on their own edges, and outputs appear in the order of their falling edges.
- R9: With FILTER_EN = 0, every record, rising or falling, is emitted unchanged and in arrival order.
- R10: While out_valid is 1 and out_ready is 0, in_ready is 0 and the output record stays stable.
- R11: A synchronous active-high reset empties every slot and clears out_valid. A falling record that arrives after reset therefore produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input record valid |
| in_ready | output | 1 | Block can accept an input record |
| in_chan | input | 3 | Input channel number (0 to NUM_CH−1) |
| in_rising | input | 1 | 1 = rising edge, 0 = falling edge |
| in_sec | input | 32 | Seconds count of the edge |
| in_ticks | input | 27 | 8 ns tick count within the second |
| out_valid | output | 1 | Output record valid |
| out_ready | input | 1 | Consumer accepts the output record |
| out_chan | output | 3 | Output channel number |
| out_rising | output | 1 | Output slope flag |
| out_sec | output | 32 | Output seconds count |
| out_ticks | output | 27 | Output tick count |

## Verification
Directed pulses sit on each edge of the window: MIN_TICKS−1 against MIN_TICKS, exactly one second against one tick more, and a two-second gap. These separate an off-by-one in either bound. Pulses that straddle a second boundary separate a correct wrapped subtraction from a naive tick difference. A double rising edge is chosen so that the older and newer rising records would both pass, which shows which one was kept. A stray falling edge and interleaved channels show that slots are independent. A seeded random stream of mixed widths, stray edges and a randomly stalling consumer runs against a bench model of slots and widths. A second instance with the filter off checks pass-through order.

// File: rtl/pwf_pkg.sv
package pwf_pkg;

    localparam int CH_W          = 3;
    localparam int SEC_W         = 32;
    localparam int TICK_W        = 27;
    localparam int SPAN_W        = 32;
    localparam logic [SPAN_W-1:0] TICKS_PER_SEC = 32'd125_000_000;

    typedef struct packed {
        logic [CH_W-1:0]   chan;
        logic              rising;
        logic [SEC_W-1:0]  sec;
        logic [TICK_W-1:0] ticks;
    } ts_t;

    // Pulse span in ticks between a rising and falling stamp, judged
    // against [min_ticks, one second]. Spans of two or more second
    // boundaries, or falls before the rise, are rejected outright.
    function automatic logic span_in_window(ts_t rise_ts, ts_t fall_ts,
                                            logic [SPAN_W-1:0] min_ticks);
        logic [SEC_W-1:0]  dsec;
        logic [SPAN_W-1:0] span;
        dsec = fall_ts.sec - rise_ts.sec;
        if (dsec == '0) begin
            if (fall_ts.ticks < rise_ts.ticks) return 1'b0;
            span = SPAN_W'(fall_ts.ticks) - SPAN_W'(rise_ts.ticks);
        end else if (dsec == SEC_W'(1)) begin
            span = TICKS_PER_SEC - SPAN_W'(rise_ts.ticks) + SPAN_W'(fall_ts.ticks);
        end else begin
            return 1'b0;
        end
        return (span >= min_ticks) && (span <= TICKS_PER_SEC);
    endfunction

endpackage

// File: rtl/pwf_width_check.sv
module pwf_width_check
    import pwf_pkg::*;
#(
    parameter int unsigned MIN_TICKS = 12
) (
    input  ts_t  rise_ts,
    input  ts_t  fall_ts,
    output logic accept
);
    localparam logic [SPAN_W-1:0] MIN_SPAN = SPAN_W'(MIN_TICKS);

    always_comb accept = span_in_window(rise_ts, fall_ts, MIN_SPAN);
endmodule

// File: rtl/pwf_pending_bank.sv
module pwf_pending_bank
    import pwf_pkg::*;
#(
    parameter int NUM_CH = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            park_en,
    input  ts_t             park_ts,
    input  logic            drop_en,
    input  logic [CH_W-1:0] sel_chan,
    output logic            held_valid,
    output ts_t             held_ts
);
    logic [NUM_CH-1:0] slot_vld;
    ts_t               slot_ts [NUM_CH];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_vld[i] <= 1'b0;
            end else if (park_en && park_ts.chan == CH_W'(i)) begin
                slot_vld[i] <= 1'b1;
            end else if (drop_en && sel_chan == CH_W'(i)) begin
                slot_vld[i] <= 1'b0;
            end
        end
        always_ff @(posedge clk) begin
            if (park_en && park_ts.chan == CH_W'(i)) slot_ts[i] <= park_ts;
        end
    end

    always_comb begin
        held_valid = 1'b0;
        held_ts    = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (sel_chan == CH_W'(i)) begin
                held_valid = slot_vld[i];
                held_ts    = slot_ts[i];
            end
        end
    end

    // A record is either a rising park or a falling release, never both.
    p_one_op_r6: assert property (@(posedge clk) disable iff (rst)
        !(park_en && drop_en));

    // Releasing a slot always leaves it empty on the next cycle (R7).
    p_release_empties_r7: assert property (@(posedge clk) disable iff (rst)
        drop_en && !park_en |=> !held_valid || sel_chan != $past(sel_chan));
endmodule

// File: rtl/pwf_out_stage.sv
module pwf_out_stage
    import pwf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  ts_t  load_ts,
    input  logic out_ready,
    output logic out_valid,
    output ts_t  out_ts,
    output logic can_load
);
    assign can_load = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else if (load) begin
            out_valid <= 1'b1;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (load) out_ts <= load_ts;
    end

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_ts));

    p_reset_clear_r11: assert property (@(posedge clk)
        rst |=> !out_valid);

    p_no_overwrite_r10: assert property (@(posedge clk) disable iff (rst)
        load |-> !out_valid || out_ready);
endmodule

// File: rtl/timestamp_pw_filter.sv
module timestamp_pw_filter
    import pwf_pkg::*;
#(
    parameter bit          FILTER_EN = 1'b1,
    parameter int unsigned MIN_TICKS = 12,
    parameter int          NUM_CH    = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [CH_W-1:0]   in_chan,
    input  logic              in_rising,
    input  logic [SEC_W-1:0]  in_sec,
    input  logic [TICK_W-1:0] in_ticks,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [CH_W-1:0]   out_chan,
    output logic              out_rising,
    output logic [SEC_W-1:0]  out_sec,
    output logic [TICK_W-1:0] out_ticks
);
    ts_t  in_ts, load_ts, out_ts;
    logic fire, load, can_load;

    assign in_ts    = {in_chan, in_rising, in_sec, in_ticks};
    assign in_ready = can_load;
    assign fire     = in_valid && can_load;
    assign {out_chan, out_rising, out_sec, out_ticks} = out_ts;

    if (FILTER_EN) begin : g_filter
        logic held_valid, accept;
        ts_t  held_ts;

        pwf_pending_bank #(.NUM_CH(NUM_CH)) u_bank (
            .clk        (clk),
            .rst        (rst),
            .park_en    (fire && in_rising),
            .park_ts    (in_ts),
            .drop_en    (fire && !in_rising),
            .sel_chan   (in_chan),
            .held_valid (held_valid),
            .held_ts    (held_ts)
        );

        pwf_width_check #(.MIN_TICKS(MIN_TICKS)) u_check (
            .rise_ts (held_ts),
            .fall_ts (in_ts),
            .accept  (accept)
        );

        assign load    = fire && !in_rising && held_valid && accept;
        assign load_ts = held_ts;

        p_no_fall_r1: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> out_rising);

        p_emit_after_fall_r2: assert property (@(posedge clk) disable iff (rst)
            $rose(out_valid) |-> $past(in_valid && in_ready && !in_rising));
    end else begin : g_bypass
        assign load    = fire;
        assign load_ts = in_ts;

        p_pass_all_r9: assert property (@(posedge clk) disable iff (rst)
            in_valid && in_ready |=> out_valid && out_chan == $past(in_chan)
                && out_rising == $past(in_rising) && out_ticks == $past(in_ticks));
    end

    pwf_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_ts   (load_ts),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_ts    (out_ts),
        .can_load  (can_load)
    );

    p_stall_blocks_r10: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |-> !in_ready);
endmodule

// File: tb/timestamp_pw_filter_test.sv
module timestamp_pw_filter_test;
    import pwf_pkg::*;

    localparam longint TPS  = 125000000;
    localparam int     MINW = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic              vf = 1'b0, vb = 1'b0;
    logic [CH_W-1:0]   d_chan = '0;
    logic              d_rise = 1'b0;
    logic [SEC_W-1:0]  d_sec = '0;
    logic [TICK_W-1:0] d_ticks = '0;
    logic              out_ready = 1'b1;

    logic rdy_f, ov_f, or_f, rdy_b, ov_b, or_b;
    logic [CH_W-1:0] oc_f, oc_b;
    logic [SEC_W-1:0] os_f, os_b;
    logic [TICK_W-1:0] ot_f, ot_b;

    timestamp_pw_filter #(.FILTER_EN(1'b1)) uut (
        .clk(clk), .rst(rst), .in_valid(vf), .in_ready(rdy_f),
        .in_chan(d_chan), .in_rising(d_rise), .in_sec(d_sec), .in_ticks(d_ticks),
        .out_valid(ov_f), .out_ready(out_ready), .out_chan(oc_f),
        .out_rising(or_f), .out_sec(os_f), .out_ticks(ot_f));

    timestamp_pw_filter #(.FILTER_EN(1'b0)) uut_bypass (
        .clk(clk), .rst(rst), .in_valid(vb), .in_ready(rdy_b),
        .in_chan(d_chan), .in_rising(d_rise), .in_sec(d_sec), .in_ticks(d_ticks),
        .out_valid(ov_b), .out_ready(out_ready), .out_chan(oc_b),
        .out_rising(or_b), .out_sec(os_b), .out_ticks(ot_b));

    int    checks = 0, fails = 0;
    bit    done = 0;
    int    ready_mode = 1;   // 0 low, 1 high, 2 random
    string cur_tag = "R2";

    ts_t   qf[$], qb[$];
    string tf[$];
    bit    pend_v[8];
    ts_t   pend_t[8];

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic bit pulse_ok(ts_t r, ts_t f);
        longint w;
        w = (longint'(f.sec) - longint'(r.sec)) * TPS + longint'(f.ticks) - longint'(r.ticks);
        return (w >= MINW) && (w <= TPS);
    endfunction

    // Reference model of the filtering instance
    task automatic model_f(ts_t t);
        if (t.rising) begin
            pend_v[t.chan] = 1'b1;      // R6: overwrite
            pend_t[t.chan] = t;
        end else if (pend_v[t.chan]) begin
            if (pulse_ok(pend_t[t.chan], t)) begin
                qf.push_back(pend_t[t.chan]);
                tf.push_back(cur_tag);
            end
            pend_v[t.chan] = 1'b0;
        end                             // R7: stray fall dropped
    endtask

    task automatic send(bit byp, int ch, bit rise, longint sec, longint ticks);
        ts_t t;
        t = {CH_W'(ch), rise, SEC_W'(sec), TICK_W'(ticks)};
        @(posedge clk); #1;
        {d_chan, d_rise, d_sec, d_ticks} = t;
        if (byp) vb = 1'b1; else vf = 1'b1;
        forever begin
            @(negedge clk);
            if (byp ? rdy_b : rdy_f) break;
        end
        if (byp) qb.push_back(t); else model_f(t);
        @(posedge clk); #1;
        vf = 1'b0; vb = 1'b0;
    endtask

    task automatic pulse(int ch, longint rs, longint rt, longint w);
        longint tot;
        tot = rt + w;
        send(0, ch, 1, rs, rt);
        send(0, ch, 0, rs + tot / TPS, tot % TPS);
    endtask

    // Output monitors: a transfer seen at a negedge completes at the next posedge
    always @(negedge clk) begin
        if (!rst && ov_f && out_ready) begin
            if (qf.size() == 0) begin
                check(0, "R1", "unexpected output", {oc_f, or_f, os_f, ot_f}, 0);
            end else begin
                ts_t e; string tg;
                e = qf.pop_front(); tg = tf.pop_front();
                check({oc_f, or_f, os_f, ot_f} == e, tg, "filtered output", {oc_f, or_f, os_f, ot_f}, e);
            end
        end
        if (!rst && ov_b && out_ready) begin
            if (qb.size() == 0) begin
                check(0, "R9", "unexpected bypass output", {oc_b, or_b, os_b, ot_b}, 0);
            end else begin
                ts_t e;
                e = qb.pop_front();
                check({oc_b, or_b, os_b, ot_b} == e, "R9", "bypass output", {oc_b, or_b, os_b, ot_b}, e);
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk); #1;
            case (ready_mode)
                0: out_ready = 1'b0;
                1: out_ready = 1'b1;
                default: out_ready = ($urandom % 4) != 0;
            endcase
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        check(0, "R2", "watchdog expired", 0, 1);
        finish_run();
    end

    task automatic drain();
        ready_mode = 1;
        repeat (20) @(posedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R11: state out of reset
        check(ov_f == 0 && ov_b == 0, "R11", "out_valid after reset", {ov_f, ov_b}, 0);
        check(rdy_f == 1, "R11", "in_ready after reset", rdy_f, 1);

        cur_tag = "R2";  pulse(0, 5, 1000, 100);
        cur_tag = "R4";  pulse(1, 6, 200, MINW - 1); pulse(1, 6, 400, MINW);
        cur_tag = "R3";  pulse(2, 7, 500, TPS); pulse(2, 7, 500, TPS + 1);
        pulse(2, 7, 500, 2 * TPS);
        cur_tag = "R5";  pulse(4, 10, 124999990, 15); pulse(4, 10, 124999999, 6);
        cur_tag = "R6";
        send(0, 0, 1, 20, 0); send(0, 0, 1, 20, 100); send(0, 0, 0, 20, 150);
        cur_tag = "R7";
        send(0, 1, 0, 21, 500); send(0, 1, 0, 21, 900);
        cur_tag = "R8";
        send(0, 0, 1, 30, 0); send(0, 1, 1, 30, 10); send(0, 1, 0, 30, 40);
        send(0, 0, 0, 30, 5);
        send(0, 2, 1, 31, 0); send(0, 3, 1, 31, 0); send(0, 3, 0, 31, 100);
        send(0, 2, 0, 31, 200);
        drain();
        check(qf.size() == 0, "R2", "directed outputs all seen", qf.size(), 0);

        // R10: stalled consumer
        ready_mode = 0;
        cur_tag = "R10";
        @(posedge clk);
        pulse(1, 40, 100, 100);
        repeat (3) begin
            @(negedge clk);
            check(ov_f == 1 && rdy_f == 0, "R10", "stall holds valid, blocks input", {ov_f, rdy_f}, 2'b10);
            if (qf.size() > 0)
                check({oc_f, or_f, os_f, ot_f} == qf[0], "R10", "stalled data stable", {oc_f, or_f, os_f, ot_f}, qf[0]);
        end
        drain();

        // R11: reset empties slots
        send(0, 3, 1, 50, 0);
        @(posedge clk); #1 rst = 1'b1;
        foreach (pend_v[i]) pend_v[i] = 1'b0;
        @(posedge clk); @(posedge clk); #1 rst = 1'b0;
        cur_tag = "R11";
        send(0, 3, 0, 50, 50);
        pulse(3, 51, 0, 60);
        drain();
        check(qf.size() == 0, "R11", "post-reset outputs", qf.size(), 0);

        // Random mix against the model
        ready_mode = 2;
        cur_tag = "R8";
        for (int n = 0; n < 400; n++) begin
            int ch; longint rs, rt, w;
            ch = $urandom % 5;
            rs = 100 + $urandom % 4;
            rt = $urandom % TPS;
            case ($urandom % 6)
                0: w = $urandom % 30;
                1: w = TPS - 3 + $urandom % 6;
                2: w = $urandom % 200000000;
                3: begin send(0, ch, 0, rs, rt); continue; end
                4: begin send(0, ch, 1, rs, rt); continue; end
                default: w = 2 * TPS + $urandom % 1000;
            endcase
            pulse(ch, rs, rt, w);
        end
        drain();
        check(qf.size() == 0, "R8", "random outputs all seen", qf.size(), 0);

        // R9: bypass instance passes everything in order
        ready_mode = 2;
        for (int n = 0; n < 60; n++)
            send(1, $urandom % 5, $urandom % 2, $urandom % 8, $urandom % TPS);
        drain();
        check(qf.size() == 0 && qb.size() == 0, "R9", "bypass outputs all seen", qb.size(), 0);
        finish_run();
    end
endmodule